// File: doc/BRIEF.md
# Serial Channel Interrupt and Wait/Request Control

This block holds the 8-bit interrupt and handshake control register of one serial channel. It turns the channel's condition flags into latched interrupt causes and one interrupt request. It also drives a single handshake pin. That pin can hold off a processor that reaches the data buffer too early, or it can act as an active-low transfer request for a DMA engine.

The channel logic supplies two buffer levels: the receive buffer holds a character, and the transmit buffer is empty. It also supplies single-cycle pulses for a parity error, an overrun or framing error, and an external/status change, together with the processor's read and write attempts on the data buffer. Software writes the control byte through a write strobe. Software clears each latched cause through a dedicated acknowledge bit. The serial shifter, interrupt vectoring and priority chaining live elsewhere.

Control byte layout: bit 7 enables the pin, bit 6 selects request (1) or wait (0), bit 5 ties the pin to the receive buffer (1) or the transmit buffer (0), bits 4:3 select the receive interrupt mode, bit 2 counts parity errors as special conditions, bit 1 enables the transmit-empty cause, and bit 0 enables the external/status cause. Cause bit positions in `pending` and `ack`: 0 received character, 1 special condition, 2 transmit buffer empty, 3 external/status.

Top module: `chan_irq_ctl`

## Requirements
- R1: After a reset the control byte is zero, `pending` is 0000, `irq` is 0 and `wreq_oe` is 0, whatever the other inputs are.
- R2: With control bit 7 clear, `wreq_oe` is 0 for every value of the other inputs and control bits.
- R3: With bit 7 set and bit 6 clear (wait), the pin is driven (`wreq_oe`=1, `wreq_out`=0) only while the selected attempt is active and the selected buffer is not ready. Otherwise it floats. The receive side means `cpu_rd_try` with `rx_avail`. The transmit side means `cpu_wr_try` with `tx_empty`.
- R4: With bits 7 and 6 set (request), `wreq_oe` is 1 and `wreq_out` is 0 while the selected buffer is ready, and 1 otherwise.
- R5: Control bit 5 set selects the receive buffer for the pin. When clear, the pin uses the transmit buffer.
- R6: Receive mode 00 latches neither a received-character cause nor a special-condition cause.
- R7: Receive mode 01 latches cause 0 only on the first rising edge of `rx_avail` after a control write whose bits 4:3 are 01. Each such write re-arms it.
- R8: Receive mode 10 latches cause 0 on every rising edge of `rx_avail`, and it also latches special conditions.
- R9: Receive mode 11 latches special conditions but never cause 0.
- R10: In any nonzero receive mode, `rx_special` latches cause 1. `rx_parity_err` latches cause 1 only when control bit 2 is set.
- R11: A rising edge of `tx_empty` latches cause 2 only with control bit 1 set. A pulse on `ext_change` latches cause 3 only with control bit 0 set.
- R12: An acknowledge bit clears its cause one cycle later. A new event for the same cause in the same cycle wins over the acknowledge.
- R13: `irq` is the OR of the latched causes whose enable is still on. Clearing an enable drops `irq` but leaves the cause in `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| rx_avail | input | 1 | Receive buffer holds a character (level) |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_special | input | 1 | Overrun or framing error pulse |
| tx_empty | input | 1 | Transmit buffer empty (level) |
| ext_change | input | 1 | External/status change pulse |
| cpu_rd_try | input | 1 | Processor attempting a data buffer read |
| cpu_wr_try | input | 1 | Processor attempting a data buffer write |
| ack | input | 4 | Per-cause clear strobes |
| irq | output | 1 | Interrupt request |
| wreq_out | output | 1 | Wait/request pin value, meaningful while driven |
| wreq_oe | output | 1 | Wait/request pin output enable |
| pending | output | 4 | Latched causes |

## Verification
A control write takes effect at the clock edge that samples the strobe. The pin outputs are combinational from the control byte and the current levels and attempts, so the bench changes inputs on a falling edge and reads the pin on the next falling edge. A latched cause and `irq` appear one edge after the event or the level's rising edge, and an acknowledge takes effect one edge after it is driven. The bench therefore always samples exactly one falling edge after the stimulus edge. The pin sweep covers all 256 control bytes against all 16 combinations of levels and attempts.

// File: rtl/chan_irq_pkg.sv
// Shared constants for the channel interrupt controller.
// Assumes the control byte layout fixed by the channel's register decode.
package chan_irq_pkg;
    localparam int CFG_W    = 8;
    localparam int N_CAUSE  = 4;
    localparam int MODE_W   = 2;
    // control bit positions
    localparam int B_PIN_EN = 7;
    localparam int B_REQ    = 6;
    localparam int B_RXSEL  = 5;
    localparam int B_MODE   = 3;
    localparam int B_PAR    = 2;
    localparam int B_TXIE   = 1;
    localparam int B_EXTIE  = 0;
    // cause indices
    localparam int C_RXC = 0;
    localparam int C_SPC = 1;
    localparam int C_TXE = 2;
    localparam int C_EXT = 3;

    typedef enum logic [MODE_W-1:0] {
        RXM_OFF   = 2'b00,
        RXM_FIRST = 2'b01,
        RXM_ALL   = 2'b10,
        RXM_SPC   = 2'b11
    } rx_mode_t;
endpackage

// File: rtl/chirq_cfg_reg.sv
// Control byte register, first-character arming flag and buffer level edge detect.
// Assumes rx_avail and tx_empty are synchronous levels.
module chirq_cfg_reg
    import chan_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rx_avail,
    input  logic             tx_empty,
    output logic [CFG_W-1:0] cfg,
    output logic             armed,
    output logic             rx_rise,
    output logic             tx_rise
);
    logic rx_prev, tx_prev;
    logic first_mode;

    assign first_mode = (rx_mode_t'(cfg[B_MODE +: MODE_W]) == RXM_FIRST);
    assign rx_rise    = rx_avail & ~rx_prev;
    assign tx_rise    = tx_empty & ~tx_prev;

    // Purpose: hold the control byte written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_we) cfg <= cfg_wdata;
    end

    // Purpose: arm on a write selecting first-character mode, disarm on that character.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (cfg_we && rx_mode_t'(cfg_wdata[B_MODE +: MODE_W]) == RXM_FIRST)
            armed <= 1'b1;
        else if (rx_rise && first_mode)
            armed <= 1'b0;
    end

    // Purpose: remember previous buffer levels for rising edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev <= 1'b0;
            tx_prev <= 1'b0;
        end else begin
            rx_prev <= rx_avail;
            tx_prev <= tx_empty;
        end
    end

    // R7: a character in first mode consumes the arm
    a_r7_arm_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rx_avail && !rx_prev && first_mode && !cfg_we) |=> !armed);
    // R7: a write selecting mode 01 re-arms
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[B_MODE +: MODE_W] == 2'b01) |=> armed);
endmodule

// File: rtl/chirq_causes.sv
// Latches interrupt causes gated by their enables and forms the request.
// Assumes event inputs are single-cycle and acknowledges are per cause.
module chirq_causes
    import chan_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg,
    input  logic               armed,
    input  logic               rx_rise,
    input  logic               tx_rise,
    input  logic               rx_parity_err,
    input  logic               rx_special,
    input  logic               ext_change,
    input  logic [N_CAUSE-1:0] ack,
    output logic [N_CAUSE-1:0] pending,
    output logic               irq
);
    rx_mode_t           mode;
    logic [N_CAUSE-1:0] set_v;
    logic [N_CAUSE-1:0] en_v;

    assign mode = rx_mode_t'(cfg[B_MODE +: MODE_W]);

    // Purpose: decode which causes are enabled and which fire this cycle.
    always_comb begin
        en_v        = '0;
        en_v[C_RXC] = (mode == RXM_FIRST) || (mode == RXM_ALL);
        en_v[C_SPC] = (mode != RXM_OFF);
        en_v[C_TXE] = cfg[B_TXIE];
        en_v[C_EXT] = cfg[B_EXTIE];
        set_v        = '0;
        set_v[C_RXC] = rx_rise && ((mode == RXM_ALL) || (mode == RXM_FIRST && armed));
        set_v[C_SPC] = en_v[C_SPC] && (rx_special || (rx_parity_err && cfg[B_PAR]));
        set_v[C_TXE] = tx_rise && cfg[B_TXIE];
        set_v[C_EXT] = ext_change && cfg[B_EXTIE];
    end

    for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
        // Purpose: one latched cause, event wins over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        pending[i] <= 1'b0;
            else if (set_v[i]) pending[i] <= 1'b1;
            else if (ack[i])   pending[i] <= 1'b0;
        end

        // R12: acknowledge without event clears the cause
        a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !set_v[i]) |=> !pending[i]);
        // R12: an event always leaves the cause latched
        a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> pending[i]);
    end

    assign irq = |(pending & en_v);

    // R13: no latched cause means no request
    a_r13_no_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !irq);
endmodule

// File: rtl/chirq_pin.sv
// Drives the combined wait/request pin from the control byte and buffer state.
// Assumes the pad turns wreq_oe low into high impedance.
module chirq_pin
    import chan_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             rx_avail,
    input  logic             tx_empty,
    input  logic             cpu_rd_try,
    input  logic             cpu_wr_try,
    output logic             wreq_out,
    output logic             wreq_oe
);
    logic ready, attempt;

    // Purpose: pick buffer readiness and processor attempt from the tied side.
    always_comb begin
        ready   = cfg[B_RXSEL] ? rx_avail   : tx_empty;
        attempt = cfg[B_RXSEL] ? cpu_rd_try : cpu_wr_try;
    end

    // Purpose: form pin value and enable for wait or request function.
    always_comb begin
        wreq_oe  = 1'b0;
        wreq_out = 1'b0;
        if (cfg[B_PIN_EN]) begin
            if (cfg[B_REQ]) begin
                wreq_oe  = 1'b1;
                wreq_out = ~ready;
            end else begin
                wreq_oe  = attempt & ~ready;
                wreq_out = 1'b0;
            end
        end
    end

    // R2: pin disabled means floating
    a_r2_pin_float: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[B_PIN_EN] |-> !wreq_oe);
    // R4: request function always drives
    a_r4_req_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[B_PIN_EN] && cfg[B_REQ]) |-> wreq_oe);
    // R3: wait function only ever pulls low
    a_r3_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wreq_oe && !cfg[B_REQ]) |-> !wreq_out);
endmodule

// File: rtl/chan_irq_ctl.sv
// Top of the serial channel interrupt and wait/request controller.
// Assumes all inputs synchronous to clk; pin outputs are combinational.
module chan_irq_ctl
    import chan_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               rx_avail,
    input  logic               rx_parity_err,
    input  logic               rx_special,
    input  logic               tx_empty,
    input  logic               ext_change,
    input  logic               cpu_rd_try,
    input  logic               cpu_wr_try,
    input  logic [N_CAUSE-1:0] ack,
    output logic               irq,
    output logic               wreq_out,
    output logic               wreq_oe,
    output logic [N_CAUSE-1:0] pending
);
    logic [CFG_W-1:0] cfg;
    logic armed, rx_rise, tx_rise;

    chirq_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_avail(rx_avail), .tx_empty(tx_empty),
        .cfg(cfg), .armed(armed), .rx_rise(rx_rise), .tx_rise(tx_rise)
    );

    chirq_causes u_causes (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .armed(armed),
        .rx_rise(rx_rise), .tx_rise(tx_rise),
        .rx_parity_err(rx_parity_err), .rx_special(rx_special),
        .ext_change(ext_change), .ack(ack),
        .pending(pending), .irq(irq)
    );

    chirq_pin u_pin (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .rx_avail(rx_avail), .tx_empty(tx_empty),
        .cpu_rd_try(cpu_rd_try), .cpu_wr_try(cpu_wr_try),
        .wreq_out(wreq_out), .wreq_oe(wreq_oe)
    );

    // R1: request never raised out of reset with nothing latched
    a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !irq);
endmodule

// File: tb/chan_irq_ctl_test.sv
// Self-checking bench: pin sweep over all control bytes and per-mode interrupt sequences.
module chan_irq_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_avail = 1'b0, rx_parity_err = 1'b0, rx_special = 1'b0;
    logic       tx_empty = 1'b0, ext_change = 1'b0;
    logic       cpu_rd_try = 1'b0, cpu_wr_try = 1'b0;
    logic [3:0] ack = '0;
    logic       irq, wreq_out, wreq_oe;
    logic [3:0] pending;

    int total = 0;
    int bad = 0;

    chan_irq_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_avail(rx_avail), .rx_parity_err(rx_parity_err), .rx_special(rx_special),
        .tx_empty(tx_empty), .ext_change(ext_change),
        .cpu_rd_try(cpu_rd_try), .cpu_wr_try(cpu_wr_try), .ack(ack),
        .irq(irq), .wreq_out(wreq_out), .wreq_oe(wreq_oe), .pending(pending)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic ack_all();
        ack = 4'hF; tick(); ack = 4'h0;
    endtask

    // one character arrival: level rises, cause sampled one edge later
    task automatic char_in(output logic [3:0] p);
        rx_avail = 1'b1; tick();
        p = pending;
        rx_avail = 1'b0; tick();
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] p;
        // R1: reset state with active inputs
        rx_avail = 1'b1; tx_empty = 1'b1; cpu_rd_try = 1'b1; cpu_wr_try = 1'b1;
        do_reset();
        check("R1 pending", {4'h0, pending}, 8'h00);
        check("R1 irq", {7'h0, irq}, 8'h00);
        check("R1 oe", {7'h0, wreq_oe}, 8'h00);
        rx_avail = 1'b0; tx_empty = 1'b0; cpu_rd_try = 1'b0; cpu_wr_try = 1'b0;

        // R2 R3 R4 R5: sweep every control byte against every level/attempt combination
        for (int c = 0; c < 256; c++) begin
            write_cfg(c[7:0]);
            for (int k = 0; k < 16; k++) begin
                logic rdy, att, e_oe, e_out;
                rx_avail = k[0]; tx_empty = k[1]; cpu_rd_try = k[2]; cpu_wr_try = k[3];
                tick();
                rdy = c[5] ? k[0] : k[1];
                att = c[5] ? k[2] : k[3];
                if (!c[7])     begin e_oe = 1'b0;       e_out = 1'b0; end
                else if (c[6]) begin e_oe = 1'b1;       e_out = ~rdy; end
                else           begin e_oe = att & ~rdy; e_out = 1'b0; end
                check(!c[7] ? "R2 pin" : (c[6] ? "R4 R5 pin" : "R3 R5 pin"),
                      {6'h0, wreq_oe, wreq_oe & wreq_out}, {6'h0, e_oe, e_oe & e_out});
            end
        end
        rx_avail = 1'b0; tx_empty = 1'b0; cpu_rd_try = 1'b0; cpu_wr_try = 1'b0;

        // R6 R7 R8 R9 R10: receive modes with and without parity as special
        for (int m = 0; m < 4; m++) begin
            for (int pb = 0; pb < 2; pb++) begin
                logic [7:0] cv;
                logic e_first, e_again, e_spc, e_par;
                cv = 8'((m << 3) | (pb << 2));
                e_first = (m == 1) || (m == 2);
                e_again = (m == 2);
                e_spc   = (m != 0);
                e_par   = (m != 0) && (pb == 1);
                do_reset();
                write_cfg(cv);
                char_in(p);
                check(m == 0 ? "R6 char" : (m == 1 ? "R7 first" : (m == 2 ? "R8 char" : "R9 char")),
                      {7'h0, p[0]}, {7'h0, e_first});
                check("R13 irq char", {7'h0, irq}, {7'h0, e_first});
                ack_all(); tick();
                check("R12 cleared", {4'h0, pending}, 8'h00);
                char_in(p);
                check(m == 1 ? "R7 second" : "R8 R9 R6 second", {7'h0, p[0]}, {7'h0, e_again});
                ack_all();
                rx_special = 1'b1; tick(); rx_special = 1'b0;
                check(m == 0 ? "R6 special" : "R10 special", {7'h0, pending[1]}, {7'h0, e_spc});
                ack_all(); tick();
                rx_parity_err = 1'b1; tick(); rx_parity_err = 1'b0;
                check("R10 parity", {7'h0, pending[1]}, {7'h0, e_par});
                ack_all(); tick();
                if (m == 1) begin
                    write_cfg(cv);
                    char_in(p);
                    check("R7 rearm", {7'h0, p[0]}, 8'h01);
                    ack_all();
                end
            end
        end

        // R11: transmit empty and external causes gated by enables
        do_reset();
        tx_empty = 1'b1; tick(); tx_empty = 1'b0; tick();
        ext_change = 1'b1; tick(); ext_change = 1'b0;
        check("R11 disabled", {4'h0, pending}, 8'h00);
        write_cfg(8'h03);
        tx_empty = 1'b1; tick();
        check("R11 tx rise", {7'h0, pending[2]}, 8'h01);
        tick();
        ack = 4'h4; tick(); ack = 4'h0;
        check("R11 tx level no refire", {7'h0, pending[2]}, 8'h00);
        tx_empty = 1'b0;
        ext_change = 1'b1; tick(); ext_change = 1'b0;
        check("R11 ext", {4'h0, pending}, 8'h08);

        // R12: event wins over acknowledge in the same cycle, then ack alone clears
        ext_change = 1'b1; ack = 4'h8; tick(); ext_change = 1'b0; ack = 4'h0;
        check("R12 set wins", {7'h0, pending[3]}, 8'h01);
        ack = 4'h8; tick(); ack = 4'h0;
        check("R12 ack clears", {7'h0, pending[3]}, 8'h00);

        // R13: disabling an enable drops irq but keeps the cause
        tx_empty = 1'b1; tick(); tx_empty = 1'b0;
        check("R13 irq on", {7'h0, irq}, 8'h01);
        write_cfg(8'h01);
        check("R13 irq masked", {7'h0, irq}, 8'h00);
        check("R13 cause kept", {4'h0, pending}, 8'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule